// File: doc/BRIEF.md
# Posted Write Queue with Direct Bypass

This block sits between a processor's write port and a system bus master port. Each incoming write is sorted by its caching mode and its precision. A write is either posted into a four-deep first-in first-out queue or sent straight to the bus through a single registered output stage. Two control bits, loaded through a configuration strobe and cleared by reset, govern the sorting. The first enables queuing. The second write-protects accesses that fall outside every mapped region.

When queuing is enabled, write-through writes and imprecise cache-inhibited writes are posted. Precise cache-inhibited writes always take the direct path. When queuing is disabled, every bus-bound write is direct. A direct write waits until every older posted entry has left the queue, so bus order always equals program order. Copyback writes are absorbed by the cache and cause no bus traffic here. A write to an unmapped area while write-protect is set is dropped and reported with a one-cycle error pulse.

Top module: `wr_post_queue`

## Requirements
- R1: Reset clears both control bits and empties the queue. After reset, `bus_valid`, `acc_err` and `cpu_stall` are low. A write-through write to an unmapped area then raises no error and reaches `bus_valid` one edge after it is accepted (the direct path).
- R2: With queuing enabled, write-through writes (`cpu_cmode` = 2'b01) and cache-inhibited writes (`cpu_cmode[1]` = 1) with `cpu_precise` = 0 are posted. A posted write reaches `bus_valid` two edges after it is accepted. With the bus held not ready, five such writes are accepted (four queued and one in the output stage).
- R3: With queuing disabled, write-through and cache-inhibited writes take the direct path. With the bus held not ready, only one such write is accepted.
- R4: A cache-inhibited write with `cpu_precise` = 1 takes the direct path even when queuing is enabled.
- R5: When write-protect is set and `cpu_no_region` = 1, the write is accepted without a stall and is not performed. `acc_err` is high for exactly the one cycle after it. With `cpu_no_region` = 0, or with write-protect clear, the write proceeds normally.
- R6: A write that must be posted while the queue is full holds `cpu_stall` high. The stall falls in the cycle after one entry drains.
- R7: A direct write stalls while any posted entry is still queued. It is issued only after all older entries, so the bus sees writes in acceptance order.
- R8: An entry moves on the bus only on a cycle where `bus_valid` and `bus_ready` are both high. While `bus_valid` is high and `bus_ready` is low, the address, data and byte enables stay stable. Queued entries leave in first-in first-out order.
- R9: Copyback writes (`cpu_cmode` = 2'b00) never stall and never produce a bus cycle.
- R10: Each bus cycle carries exactly the address, data and byte enables of the write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Loads the two control bits below |
| cfg_buf_en | input | 1 | Queuing enable value to load |
| cfg_wprot | input | 1 | Default-area write-protect value to load |
| cpu_wr_valid | input | 1 | Processor presents a write |
| cpu_addr | input | AW | Write address |
| cpu_data | input | DW | Write data |
| cpu_be | input | DW/8 | Byte enables |
| cpu_cmode | input | 2 | 00 copyback, 01 write-through, 1x cache-inhibited |
| cpu_precise | input | 1 | 1 = precise access |
| cpu_no_region | input | 1 | 1 = address matched no mapped region |
| cpu_stall | output | 1 | Write not accepted this cycle |
| bus_valid | output | 1 | Bus write request valid |
| bus_ready | input | 1 | Bus accepts the request |
| bus_addr | output | AW | Bus write address |
| bus_data | output | DW | Bus write data |
| bus_be | output | DW/8 | Bus byte enables |
| acc_err | output | 1 | One-cycle access-error pulse |

## Verification
The assertions assume that the processor keeps a write's fields steady while `cpu_stall` holds it. They also assume that `bus_ready` is a plain level which the design never needs to see before it raises `bus_valid`. The stimulus drives every input on the falling edge and changes a write's fields only after the write has been accepted. It toggles `bus_ready` only between rising edges. Control bits are changed only while no write is presented.

// File: rtl/wpq_pkg.sv
`timescale 1ns/1ps
package wpq_pkg;
  typedef enum logic [1:0] {
    CM_COPYBACK    = 2'b00,
    CM_WTHRU       = 2'b01,
    CM_INHIBIT     = 2'b10,
    CM_INHIBIT_ALT = 2'b11
  } cmode_e;

  function automatic logic is_inhibit(input cmode_e m);
    return (m == CM_INHIBIT) || (m == CM_INHIBIT_ALT);
  endfunction
endpackage

// File: rtl/wpq_route.sv
`timescale 1ns/1ps
module wpq_route
  import wpq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       valid_i,
  input  logic [1:0] cmode_i,
  input  logic       precise_i,
  input  logic       no_region_i,
  input  logic       buf_en_i,
  input  logic       wprot_i,
  input  logic       q_full_i,
  input  logic       q_empty_i,
  input  logic       stage_free_i,
  output logic       fault_o,
  output logic       push_o,
  output logic       direct_go_o,
  output logic       stall_o
);
  cmode_e cm;
  logic   bus_kind, posted, direct;

  always_comb begin
    cm          = cmode_e'(cmode_i);
    fault_o     = valid_i && wprot_i && no_region_i;
    bus_kind    = valid_i && !fault_o && (cm != CM_COPYBACK);
    posted      = bus_kind && buf_en_i && !(is_inhibit(cm) && precise_i);
    direct      = bus_kind && !posted;
    push_o      = posted && !q_full_i;
    direct_go_o = direct && q_empty_i && stage_free_i;
    stall_o     = (posted && q_full_i) || (direct && !(q_empty_i && stage_free_i));
  end

  // R9
  cb_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && cmode_i == 2'b00) |-> (!stall_o && !push_o && !direct_go_o));

  // R4
  prec_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && cmode_i[1] && precise_i) |-> !push_o);

  // R5
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!stall_o && !push_o && !direct_go_o));
endmodule

// File: rtl/wpq_fifo.sv
`timescale 1ns/1ps
module wpq_fifo #(
  parameter int W     = 68,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (push_i) mem[wptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_i) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_i)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push_i && !pop_i)      count <= count + 1'b1;
      else if (pop_i && !push_i) count <= count - 1'b1;
    end
  end

  assign dout_o  = mem[rptr];
  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(push_i && full_o));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop_i && empty_o));
endmodule

// File: rtl/wr_post_queue.sv
`timescale 1ns/1ps
module wr_post_queue #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_load,
  input  logic            cfg_buf_en,
  input  logic            cfg_wprot,
  input  logic            cpu_wr_valid,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_data,
  input  logic [DW/8-1:0] cpu_be,
  input  logic [1:0]      cpu_cmode,
  input  logic            cpu_precise,
  input  logic            cpu_no_region,
  output logic            cpu_stall,
  output logic            bus_valid,
  input  logic            bus_ready,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_data,
  output logic [DW/8-1:0] bus_be,
  output logic            acc_err
);
  localparam int BW = DW / 8;
  localparam int EW = AW + DW + BW;

  logic          buf_en_q, wprot_q;
  logic          fault, push, direct_go;
  logic          q_full, q_empty, pop, stage_free;
  logic [EW-1:0] q_head, cpu_entry;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_en_q <= 1'b0;
      wprot_q  <= 1'b0;
    end else if (cfg_load) begin
      buf_en_q <= cfg_buf_en;
      wprot_q  <= cfg_wprot;
    end
  end

  assign stage_free = !bus_valid || bus_ready;
  assign pop        = !q_empty && stage_free;
  assign cpu_entry  = {cpu_addr, cpu_data, cpu_be};

  wpq_route route_i (
    .clk          (clk),
    .rst          (rst),
    .valid_i      (cpu_wr_valid),
    .cmode_i      (cpu_cmode),
    .precise_i    (cpu_precise),
    .no_region_i  (cpu_no_region),
    .buf_en_i     (buf_en_q),
    .wprot_i      (wprot_q),
    .q_full_i     (q_full),
    .q_empty_i    (q_empty),
    .stage_free_i (stage_free),
    .fault_o      (fault),
    .push_o       (push),
    .direct_go_o  (direct_go),
    .stall_o      (cpu_stall)
  );

  wpq_fifo #(.W(EW), .DEPTH(DEPTH)) fifo_i (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .din_i   (cpu_entry),
    .pop_i   (pop),
    .dout_o  (q_head),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      acc_err   <= 1'b0;
    end else begin
      acc_err <= fault;
      if (stage_free) begin
        if (pop) begin
          bus_valid                    <= 1'b1;
          {bus_addr, bus_data, bus_be} <= q_head;
        end else if (direct_go) begin
          bus_valid                    <= 1'b1;
          {bus_addr, bus_data, bus_be} <= cpu_entry;
        end else begin
          bus_valid <= 1'b0;
        end
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_valid && !acc_err));

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                   && $stable(bus_data) && $stable(bus_be)));

  // R7
  direct_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    direct_go |-> q_empty);

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(cpu_wr_valid && wprot_q && cpu_no_region));
endmodule

// File: tb/wr_post_queue_tb_top.sv
`timescale 1ns/1ps
module wr_post_queue_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0, cfg_buf_en = 1'b0, cfg_wprot = 1'b0;
  logic cpu_wr_valid = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_data = '0;
  logic [BW-1:0] cpu_be = '0;
  logic [1:0] cpu_cmode = 2'b01;
  logic cpu_precise = 1'b0, cpu_no_region = 1'b0;
  logic cpu_stall, bus_valid, acc_err;
  logic bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic [BW-1:0] bus_be;

  int n_chk = 0;
  int n_fail = 0;
  int log_n = 0;
  int err_n = 0;
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  logic [BW-1:0] log_be   [64];

  always #2.5 clk = ~clk;

  wr_post_queue dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_buf_en(cfg_buf_en),
    .cfg_wprot(cfg_wprot), .cpu_wr_valid(cpu_wr_valid), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_be(cpu_be), .cpu_cmode(cpu_cmode),
    .cpu_precise(cpu_precise), .cpu_no_region(cpu_no_region),
    .cpu_stall(cpu_stall), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be), .acc_err(acc_err)
  );

  always @(posedge clk) begin
    if (!rst && bus_valid && bus_ready && log_n < 64) begin
      log_addr[log_n] <= bus_addr;
      log_data[log_n] <= bus_data;
      log_be[log_n]   <= bus_be;
      log_n           <= log_n + 1;
    end
    if (!rst && acc_err) err_n <= err_n + 1;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cpu_wr_valid = 1'b0; bus_ready = 1'b0; cfg_load = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cfg(input logic ben, input logic wp);
    @(negedge clk);
    cfg_load = 1'b1; cfg_buf_en = ben; cfg_wprot = wp;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic drive(input logic [31:0] a, input logic [1:0] cm,
                       input logic prec, input logic nreg, input int idx);
    cpu_wr_valid = 1'b1; cpu_addr = a; cpu_data = ~a;
    cpu_be = BW'(idx + 1); cpu_cmode = cm; cpu_precise = prec; cpu_no_region = nreg;
  endtask

  task automatic t_reset();
    do_reset();
    set_cfg(1'b1, 1'b1);
    do_reset();
    #1;
    chk(!bus_valid, "R1", "bus_valid after reset", 32'(bus_valid), 0);
    chk(!acc_err, "R1", "acc_err after reset", 32'(acc_err), 0);
    chk(!cpu_stall, "R1", "stall after reset", 32'(cpu_stall), 0);
    @(negedge clk);
    drive(32'h40, 2'b01, 1'b0, 1'b1, 0);
    #1 chk(!cpu_stall, "R1", "stall on first write", 32'(cpu_stall), 0);
    @(posedge clk); #1;
    chk(bus_valid, "R1", "direct issue one edge later", 32'(bus_valid), 1);
    chk(!acc_err, "R1", "no error with protect cleared", 32'(acc_err), 0);
    @(negedge clk) cpu_wr_valid = 1'b0;
  endtask

  task automatic t_capacity(input logic ben, input logic [1:0] cm, input logic prec,
                            input int exp_acc, input string req, input logic [31:0] base);
    int acc = 0;
    int start;
    do_reset();
    set_cfg(ben, 1'b0);
    start = log_n;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      drive(base + 32'(acc * 4), cm, prec, 1'b0, acc);
      #1 if (!cpu_stall) acc++;
    end
    @(negedge clk) cpu_wr_valid = 1'b0;
    chk(acc == exp_acc, req, "writes accepted with bus held", 32'(acc), 32'(exp_acc));
    bus_ready = 1'b1;
    repeat (12) @(negedge clk);
    bus_ready = 1'b0;
    chk(log_n - start == exp_acc, req, "bus cycles", 32'(log_n - start), 32'(exp_acc));
    for (int i = 0; i < exp_acc && i < log_n - start; i++) begin
      chk(log_addr[start + i] == base + 32'(i * 4), "R8", "drain order",
          log_addr[start + i], base + 32'(i * 4));
      chk(log_data[start + i] == ~(base + 32'(i * 4)) && log_be[start + i] == BW'(i + 1),
          "R10", "payload data", log_data[start + i], ~(base + 32'(i * 4)));
    end
  endtask

  task automatic t_full_stall();
    int acc = 0;
    int start;
    do_reset();
    set_cfg(1'b1, 1'b0);
    start = log_n;
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      drive(32'h500 + 32'(acc * 4), 2'b01, 1'b0, 1'b0, acc);
      #1 if (!cpu_stall) acc++;
    end
    @(negedge clk);
    drive(32'h500 + 32'(acc * 4), 2'b01, 1'b0, 1'b0, acc);
    bus_ready = 1'b1;
    #1 chk(cpu_stall, "R6", "stall while full", 32'(cpu_stall), 1);
    @(negedge clk);
    bus_ready = 1'b0;
    #1 chk(!cpu_stall, "R6", "stall falls after one drain", 32'(cpu_stall), 0);
    @(negedge clk) cpu_wr_valid = 1'b0;
    bus_ready = 1'b1;
    repeat (12) @(negedge clk);
    bus_ready = 1'b0;
    chk(log_n - start == 6, "R6", "all six writes reached bus", 32'(log_n - start), 6);
    if (log_n - start == 6)
      chk(log_addr[start + 5] == 32'h514, "R6", "stalled write issued last",
          log_addr[start + 5], 32'h514);
  endtask

  task automatic t_order();
    int start;
    int waited = 0;
    do_reset();
    set_cfg(1'b1, 1'b0);
    start = log_n;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      drive(32'h100 + 32'(i * 4), 2'b01, 1'b0, 1'b0, i);
    end
    @(negedge clk);
    drive(32'h200, 2'b10, 1'b1, 1'b0, 3);
    for (int c = 0; c < 3; c++) begin
      #1 chk(cpu_stall, "R7", "direct write waits for queue", 32'(cpu_stall), 1);
      @(negedge clk);
    end
    bus_ready = 1'b1;
    #1;
    while (cpu_stall && waited < 10) begin
      @(negedge clk); #1; waited++;
    end
    @(negedge clk) cpu_wr_valid = 1'b0;
    repeat (5) @(negedge clk);
    bus_ready = 1'b0;
    chk(log_n - start == 4, "R7", "bus cycle count", 32'(log_n - start), 4);
    if (log_n - start == 4) begin
      chk(log_addr[start + 0] == 32'h100, "R7", "order 0", log_addr[start + 0], 32'h100);
      chk(log_addr[start + 2] == 32'h108, "R7", "order 2", log_addr[start + 2], 32'h108);
      chk(log_addr[start + 3] == 32'h200, "R7", "direct last", log_addr[start + 3], 32'h200);
    end
  endtask

  task automatic t_wprot();
    int start;
    int e0;
    do_reset();
    set_cfg(1'b1, 1'b1);
    bus_ready = 1'b1;
    start = log_n;
    e0 = err_n;
    @(negedge clk);
    drive(32'h300, 2'b01, 1'b0, 1'b1, 0);
    #1 chk(!cpu_stall, "R5", "faulting write not stalled", 32'(cpu_stall), 0);
    @(posedge clk); #1;
    chk(acc_err, "R5", "error pulse", 32'(acc_err), 1);
    @(negedge clk) cpu_wr_valid = 1'b0;
    @(posedge clk); #1;
    chk(!acc_err, "R5", "pulse lasts one cycle", 32'(acc_err), 0);
    repeat (4) @(negedge clk);
    chk(log_n == start, "R5", "faulting write not performed", 32'(log_n - start), 0);
    drive(32'h304, 2'b01, 1'b0, 1'b0, 1);
    @(negedge clk) cpu_wr_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(log_n - start == 1 && err_n - e0 == 1, "R5", "mapped write proceeds",
        32'(log_n - start), 1);
    bus_ready = 1'b0;
  endtask

  task automatic t_copyback();
    int start;
    do_reset();
    set_cfg(1'b1, 1'b0);
    start = log_n;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      drive(32'h600 + 32'(c * 4), 2'b00, c[0], 1'b0, c);
      #1 chk(!cpu_stall, "R9", "copyback never stalls", 32'(cpu_stall), 0);
    end
    @(negedge clk) cpu_wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(!bus_valid, "R9", "copyback makes no bus request", 32'(bus_valid), 0);
    bus_ready = 1'b1;
    repeat (3) @(negedge clk);
    bus_ready = 1'b0;
    chk(log_n == start, "R9", "no bus cycles", 32'(log_n - start), 0);
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_capacity(1'b1, 2'b01, 1'b0, 5, "R2", 32'h1000);
    t_capacity(1'b1, 2'b10, 1'b0, 5, "R2", 32'h2000);
    t_capacity(1'b1, 2'b11, 1'b1, 1, "R4", 32'h3000);
    t_capacity(1'b0, 2'b01, 1'b0, 1, "R3", 32'h4000);
    t_capacity(1'b0, 2'b10, 1'b0, 1, "R3", 32'h5000);
    t_full_stall();
    t_order();
    t_wprot();
    t_copyback();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule